// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits next to a small 8-bit processor core. It holds interrupt requests in latches and decides when to take one. A request is taken only in the final cycle of an instruction, and only when the global interrupt enable is set. On acceptance the block drives the core's stack pointer, program counter and byte-wide stack memory write port. It saves the 16-bit return address on the stack, low byte first, and then loads the service-routine vector. The enable flag is dropped as the request is taken.

When the core decodes a return-from-interrupt instruction it pulses a strobe. The block then reads the two saved bytes back, high byte first, and restores the program counter and stack pointer. It sets the global enable again at the end. While a sequence runs, `seq_busy` is high and the core holds its own fetch and register updates. Stack memory reads are combinational: data for `stk_addr` arrives in the same cycle.

Top module: `intr_seq_top`

## Requirements
- R1: A one-cycle pulse on `irq_req[n]` sets pending bit n. The bit stays set until its source is accepted or `irq_clr[n]` is pulsed. If a request and a clear of the same bit fall in one cycle, the bit stays set.
- R2: `take` is high only in a cycle where `insn_end`=1, `gie`=1, `seq_busy`=0, `reti`=0 and at least one bit is pending. No request is accepted while `gie`=0 or while `insn_end`=0.
- R3: Among pending sources the lowest index is accepted. Only that source's pending bit is cleared, so the others are taken on later boundaries.
- R4: The cycle after `take`, `gie` reads 0.
- R5: If `take` is high in cycle t, the push runs as follows. In cycle t+1, `stk_we`=1, `stk_addr`=SP+1 and `stk_wdata`=PC[7:0]. In cycle t+2, `stk_we`=1, `stk_addr`=SP+2 and `stk_wdata`=PC[15:8]. SP and PC here are `sp_in` and `pc_in` sampled in cycle t.
- R6: In cycle t+3, `pc_we`=1 with `pc_out`=0x0003+8*n for accepted source n, and `sp_we`=1 with `sp_out`=SP+2. `seq_busy` is 1 in cycles t+1 to t+3 and 0 in cycle t+4.
- R7: A `reti` pulse in cycle r while idle starts the return. In cycle r+1 the byte at `stk_addr`=SP becomes PC[15:8]. In cycle r+2 the byte at `stk_addr`=SP-1 becomes PC[7:0]. In cycle r+3, `pc_we` and `sp_we` are 1, with `pc_out`={hi,lo} and `sp_out`=SP-2. From r+4, `gie` is 1.
- R8: If `reti` and `insn_end` fall in the same idle cycle, the return runs and no request is accepted. Pending bits stay set and are taken at a later boundary.
- R9: `gie_wr` loads `gie_wdata` into `gie` on the next cycle, but only while idle with no acceptance in that cycle. A write made during a sequence has no effect.
- R10: All stack pointer arithmetic wraps modulo 256.
- R11: After reset, `gie`, `seq_busy`, `take`, `stk_we`, `pc_we` and `sp_we` are 0, and no bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Request pulses, one per source |
| irq_clr | input | N_SRC | Software clear of pending bits |
| gie_wr | input | 1 | Software write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| insn_end | input | 1 | Final cycle of the current instruction |
| reti | input | 1 | Return-from-interrupt decoded |
| sp_in | input | 8 | Core stack pointer |
| pc_in | input | 16 | Core return address |
| stk_rdata | input | 8 | Stack memory read data (combinational) |
| gie | output | 1 | Global interrupt enable |
| take | output | 1 | Request accepted this cycle |
| seq_busy | output | 1 | Entry or return sequence in progress |
| sp_out | output | 8 | Stack pointer value to load |
| sp_we | output | 1 | Load strobe for `sp_out` |
| pc_out | output | 16 | Program counter value to load |
| pc_we | output | 1 | Load strobe for `pc_out` |
| stk_addr | output | 8 | Stack memory address |
| stk_we | output | 1 | Stack memory write strobe |
| stk_wdata | output | 8 | Stack memory write data |

## Verification
The return strobe and an acceptance can collide. This happens when the last cycle of a return instruction is also an instruction boundary while a request is pending. The bench provokes this by driving `reti` and `insn_end` high in the same idle cycle with a pending bit and `gie` set. It expects `take` to stay low and the pop sequence to run. It also expects the pending source to be accepted on the next boundary after `gie` comes back. A second overlap is a request arriving in the same cycle as its software clear. That case is judged by whether the source is accepted later.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PC_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_VECTOR,
    ST_POP_HI,
    ST_POP_LO,
    ST_RESTORE
  } seq_state_e;
endpackage

// File: rtl/intr_req_latch.sv
module intr_req_latch #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] sw_clr,
  input  logic [N_SRC-1:0] ack_mask,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] pend_d;
  logic [N_SRC-1:0] clr_all;

  assign clr_all = sw_clr | ack_mask;

  // a new request wins over any clear in the same cycle
  always_comb begin
    pend_d = (pend_q & ~clr_all) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|($past(pend_q) & ~pend_q & ~$past(clr_all))) == 1'b0)); // R1
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] sel_idx
);
  // scan from the top so the lowest set index is kept last
  always_comb begin
    any     = 1'b0;
    sel_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any     = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
  import intr_seq_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              reti,
  input  logic              any_pend,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              gie_wr,
  input  logic              gie_wdata,
  input  logic [BYTE_W-1:0] sp_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] stk_rdata,
  output logic              take,
  output logic              busy,
  output logic              gie,
  output logic [BYTE_W-1:0] sp_out,
  output logic              sp_we,
  output logic [PC_W-1:0]   pc_out,
  output logic              pc_we,
  output logic [BYTE_W-1:0] stk_addr,
  output logic              stk_we,
  output logic [BYTE_W-1:0] stk_wdata
);
  seq_state_e        state_q, state_d;
  logic [BYTE_W-1:0] sp_q, sp_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [IDX_W-1:0]  src_q, src_d;
  logic              gie_q, gie_d;
  logic              idle;
  logic              start_ret;
  logic [PC_W-1:0]   vec_addr;

  assign idle      = (state_q == ST_IDLE);
  assign start_ret = idle && reti;
  assign take      = idle && insn_end && !reti && gie_q && any_pend;
  assign vec_addr  = PC_W'(VEC_BASE) + PC_W'(VEC_STEP) * PC_W'(src_q);

  always_comb begin
    state_d   = state_q;
    sp_d      = sp_q;
    pc_d      = pc_q;
    src_d     = src_q;
    gie_d     = gie_q;
    stk_addr  = sp_q;
    stk_we    = 1'b0;
    stk_wdata = pc_q[BYTE_W-1:0];
    pc_out    = pc_q;
    pc_we     = 1'b0;
    sp_out    = sp_q;
    sp_we     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_ret) begin
          state_d = ST_POP_HI;
          sp_d    = sp_in;
        end else if (take) begin
          state_d = ST_PUSH_LO;
          sp_d    = sp_in;
          pc_d    = pc_in;
          src_d   = sel_idx;
          gie_d   = 1'b0;
        end
        if (gie_wr && !take) gie_d = gie_wdata;
      end
      ST_PUSH_LO: begin
        stk_addr  = sp_q + 8'd1;
        stk_we    = 1'b1;
        stk_wdata = pc_q[BYTE_W-1:0];
        sp_d      = sp_q + 8'd1;
        state_d   = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        stk_addr  = sp_q + 8'd1;
        stk_we    = 1'b1;
        stk_wdata = pc_q[PC_W-1:BYTE_W];
        sp_d      = sp_q + 8'd1;
        state_d   = ST_VECTOR;
      end
      ST_VECTOR: begin
        pc_out  = vec_addr;
        pc_we   = 1'b1;
        sp_we   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_POP_HI: begin
        pc_d    = {stk_rdata, pc_q[BYTE_W-1:0]};
        sp_d    = sp_q - 8'd1;
        state_d = ST_POP_LO;
      end
      ST_POP_LO: begin
        pc_d    = {pc_q[PC_W-1:BYTE_W], stk_rdata};
        sp_d    = sp_q - 8'd1;
        state_d = ST_RESTORE;
      end
      ST_RESTORE: begin
        pc_we   = 1'b1;
        sp_we   = 1'b1;
        gie_d   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      pc_q    <= '0;
      src_q   <= '0;
      gie_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      pc_q    <= pc_d;
      src_q   <= src_d;
      gie_q   <= gie_d;
    end
  end

  assign busy = !idle;
  assign gie  = gie_q;

  AST_ENTRY_GIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q); // R4
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_HI) |-> ($past(state_q) == ST_PUSH_LO)); // R5
  AST_PUSH_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_HI) |-> (stk_addr == $past(stk_addr) + 8'd1)); // R5
  AST_VECTOR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VECTOR) |-> $past(take, 3)); // R6
  AST_POP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POP_LO) |-> ($past(state_q) == ST_POP_HI)); // R7
  AST_RETURN_GIE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESTORE) |=> gie_q); // R7
endmodule

// File: rtl/intr_seq_top.sv
module intr_seq_top #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_clr,
  input  logic             gie_wr,
  input  logic             gie_wdata,
  input  logic             insn_end,
  input  logic             reti,
  input  logic [7:0]       sp_in,
  input  logic [15:0]      pc_in,
  input  logic [7:0]       stk_rdata,
  output logic             gie,
  output logic             take,
  output logic             seq_busy,
  output logic [7:0]       sp_out,
  output logic             sp_we,
  output logic [15:0]      pc_out,
  output logic             pc_we,
  output logic [7:0]       stk_addr,
  output logic             stk_we,
  output logic [7:0]       stk_wdata
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] ack_mask;
  logic             any_pend;
  logic [IDX_W-1:0] sel_idx;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_ack
    assign ack_mask[gi] = take && (sel_idx == IDX_W'(gi));
  end

  intr_req_latch #(.N_SRC(N_SRC)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .sw_clr   (irq_clr),
    .ack_mask (ack_mask),
    .pend     (pend)
  );

  intr_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .pend    (pend),
    .any     (any_pend),
    .sel_idx (sel_idx)
  );

  intr_seq_fsm #(
    .N_SRC    (N_SRC),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_end  (insn_end),
    .reti      (reti),
    .any_pend  (any_pend),
    .sel_idx   (sel_idx),
    .gie_wr    (gie_wr),
    .gie_wdata (gie_wdata),
    .sp_in     (sp_in),
    .pc_in     (pc_in),
    .stk_rdata (stk_rdata),
    .take      (take),
    .busy      (seq_busy),
    .gie       (gie),
    .sp_out    (sp_out),
    .sp_we     (sp_we),
    .pc_out    (pc_out),
    .pc_we     (pc_we),
    .stk_addr  (stk_addr),
    .stk_we    (stk_we),
    .stk_wdata (stk_wdata)
  );
endmodule

// File: tb/intr_seq_top_test.sv
module intr_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] irq_req, irq_clr;
  logic          gie_wr, gie_wdata, insn_end, reti;
  logic [7:0]    sp_in;
  logic [15:0]   pc_in;
  logic [7:0]    stk_rdata;
  logic          gie, take, seq_busy, sp_we, pc_we, stk_we;
  logic [7:0]    sp_out, stk_addr, stk_wdata;
  logic [15:0]   pc_out;
  logic [7:0]    ram [0:255];
  int            n_chk;
  int            n_fail;
  bit            done;

  // mask, sp, pc, expected winning index
  localparam logic [29:0] TBL [0:3] = '{
    {4'b0001, 8'h10, 16'h1234, 2'd0},
    {4'b0110, 8'hFE, 16'hABCD, 2'd1},
    {4'b1100, 8'h7F, 16'h0F0F, 2'd2},
    {4'b1000, 8'hFF, 16'h8001, 2'd3}
  };

  intr_seq_top uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_clr(irq_clr),
    .gie_wr(gie_wr), .gie_wdata(gie_wdata), .insn_end(insn_end), .reti(reti),
    .sp_in(sp_in), .pc_in(pc_in), .stk_rdata(stk_rdata), .gie(gie),
    .take(take), .seq_busy(seq_busy), .sp_out(sp_out), .sp_we(sp_we),
    .pc_out(pc_out), .pc_we(pc_we), .stk_addr(stk_addr), .stk_we(stk_we),
    .stk_wdata(stk_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (stk_we) ram[stk_addr] <= stk_wdata;
  assign stk_rdata = ram[stk_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic set_gie(input logic v);
    step; gie_wr = 1'b1; gie_wdata = v;
    step; gie_wr = 1'b0;
  endtask

  task automatic pulse_req(input logic [NS-1:0] m);
    step; irq_req = m;
    step; irq_req = '0;
  endtask

  task automatic run_entry(input logic [7:0] sp, input logic [15:0] pc,
                           input int idx, input bit poke_gie);
    step; sp_in = sp; pc_in = pc; insn_end = 1'b1;
    #1 chk("R2 take on boundary", 32'(take), 32'd1);
    step; insn_end = 1'b0;
    if (poke_gie) begin gie_wr = 1'b1; gie_wdata = 1'b1; end
    #1 chk("R5 first push we", 32'(stk_we), 32'd1);
    chk("R5 first push addr (R10)", 32'(stk_addr), 32'(8'(sp + 8'd1)));
    chk("R5 first push data", 32'(stk_wdata), 32'(pc[7:0]));
    chk("R6 busy in push", 32'(seq_busy), 32'd1);
    step; gie_wr = 1'b0;
    #1 chk("R5 second push addr (R10)", 32'(stk_addr), 32'(8'(sp + 8'd2)));
    chk("R5 second push data", 32'(stk_wdata), 32'(pc[15:8]));
    chk("R4 gie cleared", 32'(gie), 32'd0);
    step;
    #1 chk("R6 pc_we", 32'(pc_we), 32'd1);
    chk("R6 vector", 32'(pc_out), 32'(3 + 8 * idx));
    chk("R6 sp_we", 32'(sp_we), 32'd1);
    chk("R6 sp_out (R10)", 32'(sp_out), 32'(8'(sp + 8'd2)));
    chk("R5 no write in vector cycle", 32'(stk_we), 32'd0);
    step;
    #1 chk("R6 busy drops", 32'(seq_busy), 32'd0);
    chk("R9 gie write during entry ignored", 32'(gie), 32'd0);
  endtask

  task automatic run_return(input logic [7:0] sp, input logic [15:0] exp_pc,
                            input bit with_boundary);
    step; sp_in = sp; reti = 1'b1; insn_end = with_boundary;
    #1 if (with_boundary) chk("R8 no take when reti collides", 32'(take), 32'd0);
    step; reti = 1'b0; insn_end = 1'b0;
    #1 chk("R7 pop high addr", 32'(stk_addr), 32'(sp));
    chk("R7 busy in pop", 32'(seq_busy), 32'd1);
    step;
    #1 chk("R7 pop low addr (R10)", 32'(stk_addr), 32'(8'(sp - 8'd1)));
    step;
    #1 chk("R7 pc restored", 32'(pc_out), 32'(exp_pc));
    chk("R7 pc_we", 32'(pc_we), 32'd1);
    chk("R7 sp restored (R10)", 32'(sp_out), 32'(8'(sp - 8'd2)));
    step;
    #1 chk("R7 gie set after return", 32'(gie), 32'd1);
    chk("R7 idle after return", 32'(seq_busy), 32'd0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    rst_n = 1'b0; irq_req = '0; irq_clr = '0; gie_wr = 1'b0; gie_wdata = 1'b0;
    insn_end = 1'b0; reti = 1'b0; sp_in = '0; pc_in = '0;
    repeat (3) step;
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 gie", 32'(gie), 32'd0);
    chk("R11 busy", 32'(seq_busy), 32'd0);
    chk("R11 take", 32'(take), 32'd0);
    chk("R11 strobes", 32'({stk_we, pc_we, sp_we}), 32'd0);
    step; insn_end = 1'b1;
    #1 chk("R11 nothing pending", 32'(take), 32'd0);
    step; insn_end = 1'b0;

    // vector table walk: entry then return
    for (int k = 0; k < 4; k++) begin
      logic [29:0] e;
      e = TBL[k];
      pulse_req(e[29:26]);
      set_gie(1'b1);
      run_entry(e[25:18], e[17:2], int'(e[1:0]), 1'b0);
      run_return(8'(e[25:18] + 8'd2), e[17:2], 1'b0);
      step; irq_clr = '1;
      step; irq_clr = '0;
    end

    // R2: gie low or no boundary means no acceptance; R1 latch holds meanwhile
    set_gie(1'b0);
    #1 chk("R9 software gie clear", 32'(gie), 32'd0);
    pulse_req(4'b0010);
    step; insn_end = 1'b1;
    #1 chk("R2 no take with gie low", 32'(take), 32'd0);
    step; insn_end = 1'b0;
    set_gie(1'b1);
    repeat (3) step;
    #1 chk("R2 no take without boundary", 32'(take), 32'd0);
    run_entry(8'h20, 16'h4455, 1, 1'b1); // R1 held, R9 write during busy
    run_return(8'h22, 16'h4455, 1'b0);

    // R3: lowest first, the other bit stays pending
    pulse_req(4'b0101);
    run_entry(8'h30, 16'h1111, 0, 1'b0);
    run_return(8'h32, 16'h1111, 1'b0);
    run_entry(8'h30, 16'h2222, 2, 1'b0);
    run_return(8'h32, 16'h2222, 1'b0);
    step; insn_end = 1'b1;
    #1 chk("R3 winners only cleared, none left", 32'(take), 32'd0);
    step; insn_end = 1'b0;

    // R1: software clear removes request; set wins over same-cycle clear
    pulse_req(4'b0010);
    step; irq_clr = 4'b0010;
    step; irq_clr = '0; insn_end = 1'b1;
    #1 chk("R1 cleared request not taken", 32'(take), 32'd0);
    step; insn_end = 1'b0; irq_req = 4'b0100; irq_clr = 4'b0100;
    step; irq_req = '0; irq_clr = '0;
    run_entry(8'h40, 16'h5678, 2, 1'b0);
    run_return(8'h42, 16'h5678, 1'b0);

    // R8: return and boundary in the same cycle
    pulse_req(4'b1000);
    ram[8'h51] = 8'h9A; ram[8'h50] = 8'hBC;
    run_return(8'h51, 16'h9ABC, 1'b1);
    run_entry(8'h60, 16'h0102, 3, 1'b0); // R8 pending taken later

    done = 1;
    report();
  end
endmodule